// File: doc/BRIEF.md
# Clear-on-Read Cycle Counter

A single memory-mapped performance register that counts core clock cycles. Software times a code sequence with two reads of the same address. The first read arms the measurement. The second read returns how many cycles went by between the two reads. Each read that hits the register returns the count held in that cycle and restarts counting. No separate clear or control register exists.

The register sits behind a simple synchronous slave port. The port has an address, a read strobe, a write strobe, write data and registered read data. Read data appears one cycle after the read strobe. In every other cycle the read data is zero.

The register is read-only. A write to its address is accepted and has no effect. A read of any other address returns zero and leaves the count alone.

When the read and write strobes are both high at the register address, the read is performed and the write is ignored. The counter wraps to zero after all-ones and does not saturate. A synchronous active-high reset sets the count and the read data to zero.

Top module: `cyc_snap_counter`

## Requirements
- R1: While no read hits the register, the count rises by exactly one on every clock edge, starting from zero after reset.
- R2: A read that hits the register puts the count held in the cycle of the read on `bus_rdata` in the next cycle, zero-extended to the bus width.
- R3: A read that hits the register leaves the count at 1 in the following cycle. Two hitting reads issued d cycles apart therefore return d, and back-to-back reads return 1 each.
- R4: A read of any address other than the register address returns zero on `bus_rdata` in the next cycle and does not change the count.
- R5: A write strobe at any address, including the register address, does not change the count. When both strobes are high at the register address, the read takes effect.
- R6: In the cycle after a cycle with no read strobe, `bus_rdata` is zero.
- R7: The count wraps from its all-ones value to zero; it never saturates.
- R8: A synchronous active-high reset sets the count and `bus_rdata` to zero on the next clock edge.
- R9: The register is decoded by a full compare of `bus_addr` with byte address 0xDE0008 (default). An address differing in any single bit is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; one count per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W (24) | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one access per cycle it is high |
| bus_wr | input | 1 | Write strobe; accepted and ignored |
| bus_wdata | input | DATA_W (32) | Write data; has no effect |
| bus_rdata | output | DATA_W (32) | Registered read data, valid the cycle after a read |

## Verification
Two functions meet in the cycle of a hitting read: the counter would normally advance, and the read must both capture the old value and restart counting. The bench provokes this with reads spaced 1 to 21 cycles apart, including runs of back-to-back reads. It judges each returned value against the spacing alone. A second collision is a read and a write strobed together at the register address. The bench checks that the read value is returned and that the next measurement still matches its spacing. A narrow second instance also drives the wrap edge into the same cycle as a read.

// File: rtl/cyc_pkg.sv
package cyc_pkg;

  // Decoded kind of bus access presented in a cycle.
  typedef enum logic [1:0] {
    ACC_IDLE    = 2'd0,
    ACC_RD_HIT  = 2'd1,
    ACC_RD_MISS = 2'd2,
    ACC_WR_HIT  = 2'd3
  } acc_e;

  localparam int unsigned DEF_ADDR_W  = 24;
  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned DEF_COUNT_W = 32;

endpackage

// File: rtl/cyc_addr_decode.sv
module cyc_addr_decode
  import cyc_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] REG_ADDR = 24'hDE0008
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output acc_e              acc
);

  logic hit;

  always_comb begin
    hit = (addr == REG_ADDR);
    // Read has priority over write when both strobes are high.
    if (rd) begin
      acc = hit ? ACC_RD_HIT : ACC_RD_MISS;
    end else if (wr && hit) begin
      acc = ACC_WR_HIT;
    end else begin
      acc = ACC_IDLE;
    end
  end

endmodule

// File: rtl/cyc_count_core.sv
module cyc_count_core #(
  parameter int unsigned COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  output logic [COUNT_W-1:0] count_q
);

  localparam logic [COUNT_W-1:0] ONE = {{(COUNT_W-1){1'b0}}, 1'b1};

  // A restart loads 1 so the read cycle itself is counted.
  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (restart) begin
      count_q <= ONE;
    end else begin
      count_q <= count_q + ONE;
    end
  end

endmodule

// File: rtl/cyc_rdata_reg.sv
module cyc_rdata_reg
  import cyc_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned COUNT_W = DEF_COUNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  acc_e               acc,
  input  logic [COUNT_W-1:0] count,
  output logic [DATA_W-1:0]  rdata
);

  logic [DATA_W-1:0] count_ext;

  generate
    if (COUNT_W == DATA_W) begin : g_full
      assign count_ext = count;
    end else begin : g_pad
      assign count_ext = {{(DATA_W-COUNT_W){1'b0}}, count};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (acc == ACC_RD_HIT) begin
      rdata <= count_ext;
    end else begin
      rdata <= '0;
    end
  end

endmodule

// File: rtl/cyc_snap_counter.sv
module cyc_snap_counter
  import cyc_pkg::*;
#(
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned COUNT_W = DEF_COUNT_W,
  parameter logic [ADDR_W-1:0] REG_ADDR = 24'hDE0008
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  acc_e               acc;
  logic               restart;
  logic [COUNT_W-1:0] count_q;

  cyc_addr_decode #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR)
  ) u_dec (
    .addr(bus_addr),
    .rd  (bus_rd),
    .wr  (bus_wr),
    .acc (acc)
  );

  assign restart = (acc == ACC_RD_HIT);

  cyc_count_core #(
    .COUNT_W(COUNT_W)
  ) u_core (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .count_q(count_q)
  );

  cyc_rdata_reg #(
    .DATA_W (DATA_W),
    .COUNT_W(COUNT_W)
  ) u_rdata (
    .clk  (clk),
    .rst  (rst),
    .acc  (acc),
    .count(count_q),
    .rdata(bus_rdata)
  );

  // Write data is accepted by the port but the register is read-only.
  logic unused_wr_sink;
  assign unused_wr_sink = ^{bus_wdata, 1'b0};

endmodule

// File: rtl/cyc_snap_checker.sv
module cyc_snap_checker #(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned COUNT_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 24'hDE0008
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_rd,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [COUNT_W-1:0] count_q
);

  localparam logic [COUNT_W-1:0] ONE = {{(COUNT_W-1){1'b0}}, 1'b1};

  logic armed = 1'b0;
  logic rd_hit;

  always_ff @(posedge clk) armed <= armed | rst;

  assign rd_hit = bus_rd && (bus_addr == REG_ADDR);

  // R1, R7: advance by one (modulo width) when no hitting read
  a_r1_step: assert property (@(posedge clk) disable iff (rst || !armed)
    !rd_hit |=> count_q == $past(count_q) + ONE);

  // R2: captured value appears next cycle
  a_r2_capture: assert property (@(posedge clk) disable iff (rst || !armed)
    rd_hit |=> bus_rdata == DATA_W'($past(count_q)));

  // R3: restart leaves count at one
  a_r3_restart: assert property (@(posedge clk) disable iff (rst || !armed)
    rd_hit |=> count_q == ONE);

  // R4: miss returns zero
  a_r4_miss_zero: assert property (@(posedge clk) disable iff (rst || !armed)
    (bus_rd && !rd_hit) |=> bus_rdata == '0);

  // R6: no read, zero data
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst || !armed)
    !bus_rd |=> bus_rdata == '0);

  // R8: reset clears both
  a_r8_reset: assert property (@(posedge clk)
    rst |=> (count_q == '0) && (bus_rdata == '0));

endmodule

bind cyc_snap_counter cyc_snap_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .COUNT_W (COUNT_W),
  .REG_ADDR(REG_ADDR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_rd   (bus_rd),
  .bus_rdata(bus_rdata),
  .count_q  (count_q)
);

// File: tb/sim_cyc_snap_counter.sv
module sim_cyc_snap_counter;

  localparam logic [23:0] HIT = 24'hDE0008;
  localparam logic [1:0] OP_RD = 2'd0, OP_MISS = 2'd1, OP_WR = 2'd2, OP_RW = 2'd3;

  typedef struct packed {
    logic [7:0]  gap;
    logic [1:0]  op;
    logic [23:0] addr;
    logic [31:0] exp;
  } vec_t;

  // Expected value = cycles since the previous hitting read.
  localparam vec_t VECS [13] = '{
    '{8'd0,  OP_RD,   HIT,          32'd1},
    '{8'd4,  OP_RD,   HIT,          32'd5},
    '{8'd2,  OP_MISS, 24'hDE0009,   32'd0},
    '{8'd1,  OP_RD,   HIT,          32'd5},
    '{8'd0,  OP_WR,   HIT,          32'd0},
    '{8'd3,  OP_RD,   HIT,          32'd5},
    '{8'd9,  OP_RW,   HIT,          32'd10},
    '{8'd0,  OP_RD,   HIT,          32'd1},
    '{8'd0,  OP_MISS, 24'hDE000C,   32'd0},
    '{8'd0,  OP_MISS, 24'h5E0008,   32'd0},
    '{8'd6,  OP_RD,   HIT,          32'd9},
    '{8'd2,  OP_WR,   24'hDE0000,   32'd0},
    '{8'd20, OP_RD,   HIT,          32'd24}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata0;
  logic [31:0] rdata1;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] got0;
  logic [31:0] got1;

  always #10 clk = ~clk;

  cyc_snap_counter u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata0)
  );

  cyc_snap_counter #(.COUNT_W(10)) u1 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata1)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Starts and ends at a falling edge; one strobed rising edge in between.
  task automatic access(input logic [1:0] op, input logic [23:0] addr);
    bus_addr  = addr;
    bus_rd    = (op == OP_RD) || (op == OP_MISS) || (op == OP_RW);
    bus_wr    = (op == OP_WR) || (op == OP_RW);
    bus_wdata = bus_wr ? 32'hFFFF_FFFF : 32'h0;
    @(negedge clk);
    got0 = rdata0;
    got1 = rdata1;
    bus_rd = 1'b0;
    bus_wr = 1'b0;
    bus_wdata = '0;
    bus_addr = '0;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    check("R8 rdata in reset", rdata0, 32'd0);
    rst = 1'b0;
    idle(4);
    access(OP_RD, HIT);
    check("R1 count from reset", got0, 32'd4);

    // Table walk
    foreach (VECS[i]) begin
      idle(int'(VECS[i].gap));
      access(VECS[i].op, VECS[i].addr);
      case (VECS[i].op)
        OP_RD:   check("R3 read spacing", got0, VECS[i].exp);
        OP_MISS: check("R4 miss reads zero", got0, VECS[i].exp);
        OP_WR:   check("R5 write ignored", got0, VECS[i].exp);
        default: check("R5 read wins over write", got0, VECS[i].exp);
      endcase
    end

    // R6: zero the cycle after a read
    access(OP_RD, HIT);
    idle(1);
    check("R6 idle rdata zero", rdata0, 32'd0);

    // R2/R3: continuous read strobe gives one per cycle
    for (int k = 0; k < 3; k++) begin
      access(OP_RD, HIT);
      check("R2 back-to-back capture", got0, 32'd2 - (k == 0 ? 32'd0 : 32'd1));
    end

    // R9: single-bit miss next to the register, count undisturbed
    idle(2);
    access(OP_MISS, HIT ^ 24'h800000);
    check("R9 top-bit miss", got0, 32'd0);
    access(OP_RD, HIT);
    check("R9 count undisturbed", got0, 32'd4);

    // R7: wrap in narrow instance, none in wide one
    idle(1023);
    access(OP_RD, HIT);
    check("R7 narrow wraps to zero", got1, 32'd0);
    check("R1 wide no wrap", got0, 32'd1024);
    idle(1024);
    access(OP_RD, HIT);
    check("R7 narrow after wrap", got1, 32'd1);
    check("R2 wide capture", got0, 32'd1025);

    // R8: mid-run reset
    idle(7);
    rst = 1'b1;
    idle(1);
    check("R8 rdata after reset", rdata0, 32'd0);
    rst = 1'b0;
    access(OP_RD, HIT);
    check("R8 count cleared by reset", got0, 32'd0);
    access(OP_RD, HIT);
    check("R3 first after reset read", got0, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule